// File: doc/BRIEF.md
# Iterative Queue-to-Link Round-Robin Matcher

This block sits in one first-stage module of a three-stage buffered Clos switch. In each cell slot it pairs that module's outgoing links to the central stage with nonempty virtual output queues. Each link gets at most one queue, and each queue gets at most one link. The pairing is built over a fixed number of grant/accept rounds, one clock each. Every link arbiter and every queue arbiter keeps its own round-robin pointer.

A slot starts with a strobe on `slot_start` while the block is idle. At that edge the block captures the nonempty vector. It then runs its rounds and presents one candidate per link: a valid flag, the queue index and the destination output module. The central stage answers with one grant bit per link, qualified by `cm_reply_valid`. Pointers move only for pairs that formed in the first round and whose link was granted. Queues are numbered `v = h*N_OM + j`, where `j` is the destination output module and `h` is the port within it.

The state machine has five states:
- `ST_IDLE` goes to `ST_REQ` on `slot_start`.
- `ST_REQ` clears the matches and goes to `ST_ITER`.
- `ST_ITER` runs for `N_ITER` cycles and then goes to `ST_WAIT_CM`.
- `ST_WAIT_CM` goes to `ST_UPDATE` on `cm_reply_valid`.
- `ST_UPDATE` goes back to `ST_IDLE`.

Top module: `lm_voq_link_matcher`

## Requirements
- R1: After reset, `cand_ready` and `link_valid` are 0, and every link and queue pointer is 0.
- R2: Queue index `v` stands for destination module `v mod N_OM` and port `v / N_OM`. `link_om[r]` always equals `link_voq[r] mod N_OM`.
- R3: Only queues whose bit was set in the captured nonempty vector are matched. No queue is matched to more than one link.
- R4: In the first round, every link searches the nonempty queues starting from its own pointer and grants the first one it finds. A queue holding several grants accepts the first granting link found starting from the queue's pointer.
- R5: In each later round, only unmatched queues request and only unmatched links grant. Grant and accept follow the same pointer order as in R4, and pairs that have formed are kept.
- R6: In `ST_UPDATE`, link pointer `r` moves to (matched queue + 1) mod the queue count, and the matched queue's pointer moves to (r + 1) mod `N_LINK`. This happens only if the pair formed in round one and `cm_grant[r]` was 1 in the reply; every other pointer holds.
- R7: `cand_ready` is 1 exactly in `ST_WAIT_CM`, first after `N_ITER + 2` rising edges counted from the edge that sampled `slot_start`. It stays 1 until a `cm_reply_valid` edge.
- R8: Outside `ST_WAIT_CM`, `link_valid` is 0. A `slot_start` seen outside `ST_IDLE` has no effect on the slot or its results.
- R9: Changes to `voq_nonempty` after the capture edge do not change that slot's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_start | input | 1 | Starts a slot when the block is idle |
| voq_nonempty | input | N_PORT*N_OM | One bit per queue, set when the queue holds a cell |
| cm_reply_valid | input | 1 | Qualifies `cm_grant` |
| cm_grant | input | N_LINK | Central-stage grant, one bit per link |
| cand_ready | output | 1 | Candidates are valid (`ST_WAIT_CM`) |
| link_valid | output | N_LINK | Link has a matched queue |
| link_voq | output | N_LINK*clog2(queues) | Matched queue index per link |
| link_om | output | N_LINK*clog2(N_OM) | Destination module per link |

## Verification
Two functions can act on the same queue within a single slot. A link's grant can be refused because the queue accepted a lower-order link, and a later round then claims that queue or that link. The bench provokes this by sweeping every nonempty pattern under every central-grant pattern, so the pointers spread out and pull the link grants apart. It judges each slot against an arithmetic model of grant, accept and pointer motion. The same slots also raise `slot_start` during `ST_REQ` and scramble `voq_nonempty` after the capture edge, and the bench checks that neither moves the result.

// File: rtl/lm_match_pkg.sv
package lm_match_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_ITER,
        ST_WAIT_CM,
        ST_UPDATE
    } match_state_e;
endpackage

// File: rtl/lm_rr_pick.sv
// First set request found at or after the pointer, wrapping around.
module lm_rr_pick #(
    parameter int W  = 4,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        int p;
        found = 1'b0;
        idx   = '0;
        for (int k = 0; k < W; k++) begin
            p = int'(ptr) + k;
            if (p >= W) p = p - W;
            if (!found && req[p]) begin
                found = 1'b1;
                idx   = IW'(p);
            end
        end
    end
endmodule

// File: rtl/lm_iter_round.sv
// One grant/accept round between free links and requesting queues.
module lm_iter_round #(
    parameter int NV = 4,
    parameter int M  = 3,
    parameter int VW = (NV > 1) ? $clog2(NV) : 1,
    parameter int LW = (M > 1) ? $clog2(M) : 1
) (
    input  logic [NV-1:0]          voq_req,
    input  logic [M-1:0]           link_free,
    input  logic [M-1:0][VW-1:0]   link_ptr,
    input  logic [NV-1:0][LW-1:0]  voq_ptr,
    output logic [M-1:0]           new_hit,
    output logic [M-1:0][VW-1:0]   new_voq
);
    logic [M-1:0]          g_found;
    logic [M-1:0][VW-1:0]  g_idx;
    logic [NV-1:0]         a_found;
    logic [NV-1:0][LW-1:0] a_idx;

    for (genvar r = 0; r < M; r++) begin : g_link
        logic [NV-1:0] masked;
        assign masked = link_free[r] ? voq_req : '0;
        lm_rr_pick #(.W(NV), .IW(VW)) u_grant (
            .req   (masked),
            .ptr   (link_ptr[r]),
            .found (g_found[r]),
            .idx   (g_idx[r])
        );
    end

    for (genvar v = 0; v < NV; v++) begin : g_voq
        logic [M-1:0] got;
        always_comb begin
            for (int r = 0; r < M; r++)
                got[r] = g_found[r] && (int'(g_idx[r]) == v);
        end
        lm_rr_pick #(.W(M), .IW(LW)) u_accept (
            .req   (got),
            .ptr   (voq_ptr[v]),
            .found (a_found[v]),
            .idx   (a_idx[v])
        );
    end

    always_comb begin
        for (int r = 0; r < M; r++) begin
            new_voq[r] = g_idx[r];
            new_hit[r] = g_found[r] && a_found[g_idx[r]]
                         && (int'(a_idx[g_idx[r]]) == r);
        end
    end
endmodule

// File: rtl/lm_voq_link_matcher.sv
module lm_voq_link_matcher
    import lm_match_pkg::*;
#(
    parameter int N_PORT = 2,
    parameter int N_OM   = 2,
    parameter int N_LINK = 3,
    parameter int N_ITER = 2,
    parameter int NV     = N_PORT * N_OM,
    parameter int VW     = (NV > 1) ? $clog2(NV) : 1,
    parameter int OW     = (N_OM > 1) ? $clog2(N_OM) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 slot_start,
    input  logic [NV-1:0]        voq_nonempty,
    input  logic                 cm_reply_valid,
    input  logic [N_LINK-1:0]    cm_grant,
    output logic                 cand_ready,
    output logic [N_LINK-1:0]    link_valid,
    output logic [N_LINK*VW-1:0] link_voq,
    output logic [N_LINK*OW-1:0] link_om
);
    localparam int LW  = (N_LINK > 1) ? $clog2(N_LINK) : 1;
    localparam int ITW = $clog2(N_ITER + 1);

    match_state_e state_q, state_d;

    logic [NV-1:0]               snap_q;
    logic [N_LINK-1:0]           match_v_q;
    logic [N_LINK-1:0][VW-1:0]   match_idx_q;
    logic [N_LINK-1:0]           first_q;
    logic [N_LINK-1:0]           cmg_q;
    logic [ITW-1:0]              it_cnt_q;
    logic [N_LINK-1:0][VW-1:0]   pl_q;
    logic [NV-1:0][LW-1:0]       pv_q;

    logic [NV-1:0]               voq_taken;
    logic [N_LINK-1:0]           new_hit;
    logic [N_LINK-1:0][VW-1:0]   new_voq;

    always_comb begin
        voq_taken = '0;
        for (int r = 0; r < N_LINK; r++)
            if (match_v_q[r]) voq_taken[match_idx_q[r]] = 1'b1;
    end

    lm_iter_round #(.NV(NV), .M(N_LINK), .VW(VW), .LW(LW)) u_round (
        .voq_req   (snap_q & ~voq_taken),
        .link_free (~match_v_q),
        .link_ptr  (pl_q),
        .voq_ptr   (pv_q),
        .new_hit   (new_hit),
        .new_voq   (new_voq)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (slot_start) state_d = ST_REQ;
            ST_REQ:     state_d = ST_ITER;
            ST_ITER:    if (it_cnt_q == ITW'(N_ITER - 1)) state_d = ST_WAIT_CM;
            ST_WAIT_CM: if (cm_reply_valid) state_d = ST_UPDATE;
            ST_UPDATE:  state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // datapath and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q      <= '0;
            match_v_q   <= '0;
            match_idx_q <= '0;
            first_q     <= '0;
            cmg_q       <= '0;
            it_cnt_q    <= '0;
            pl_q        <= '0;
            pv_q        <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (slot_start) snap_q <= voq_nonempty;
                ST_REQ: begin
                    match_v_q <= '0;
                    first_q   <= '0;
                    it_cnt_q  <= '0;
                end
                ST_ITER: begin
                    for (int r = 0; r < N_LINK; r++) begin
                        if (new_hit[r]) begin
                            match_v_q[r]   <= 1'b1;
                            match_idx_q[r] <= new_voq[r];
                            first_q[r]     <= (it_cnt_q == '0);
                        end
                    end
                    it_cnt_q <= it_cnt_q + 1'b1;
                end
                ST_WAIT_CM: if (cm_reply_valid) cmg_q <= cm_grant;
                ST_UPDATE: begin
                    for (int r = 0; r < N_LINK; r++) begin
                        if (match_v_q[r] && first_q[r] && cmg_q[r]) begin
                            pl_q[r] <= (int'(match_idx_q[r]) == NV - 1)
                                       ? '0 : match_idx_q[r] + 1'b1;
                            pv_q[match_idx_q[r]] <= (r == N_LINK - 1)
                                       ? '0 : LW'(r + 1);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        cand_ready = (state_q == ST_WAIT_CM);
        link_valid = cand_ready ? match_v_q : '0;
        for (int r = 0; r < N_LINK; r++) begin
            link_voq[r*VW +: VW] = match_idx_q[r];
            link_om[r*OW +: OW]  = OW'(int'(match_idx_q[r]) % N_OM);
        end
    end

    // checks
    for (genvar v = 0; v < NV; v++) begin : g_chk_voq
        logic [N_LINK-1:0] owners;
        always_comb begin
            for (int r = 0; r < N_LINK; r++)
                owners[r] = link_valid[r] && (int'(link_voq[r*VW +: VW]) == v);
        end
        a_r3_voq_single_link: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(owners));
    end

    for (genvar r = 0; r < N_LINK; r++) begin : g_chk_link
        a_r3_only_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
            link_valid[r] |-> snap_q[match_idx_q[r]]);
    end

    a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_UPDATE) |=> ($stable(pl_q) && $stable(pv_q)));

    a_r7_iter_to_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ITER && it_cnt_q == ITW'(N_ITER - 1)) |=> cand_ready);

    a_r8_update_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UPDATE) |=> (state_q == ST_IDLE && link_valid == '0));
endmodule

// File: tb/lm_voq_link_matcher_tb.sv
module lm_voq_link_matcher_tb_top;
    localparam int NP = 2, NO = 2, NL = 3, NI = 2;
    localparam int NV = NP * NO;
    localparam int VW = 2, OW = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_start = 1'b0;
    logic [NV-1:0] voq_nonempty = '0;
    logic cm_reply_valid = 1'b0;
    logic [NL-1:0] cm_grant = '0;
    logic cand_ready;
    logic [NL-1:0] link_valid;
    logic [NL*VW-1:0] link_voq;
    logic [NL*OW-1:0] link_om;

    int n_run = 0, n_fail = 0;
    int pl [NL];
    int pv [NV];
    int mv [NL];
    bit fst [NL];

    always #4 clk = ~clk;

    lm_voq_link_matcher #(.N_PORT(NP), .N_OM(NO), .N_LINK(NL), .N_ITER(NI)) dut_i (
        .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
        .voq_nonempty(voq_nonempty), .cm_reply_valid(cm_reply_valid),
        .cm_grant(cm_grant), .cand_ready(cand_ready), .link_valid(link_valid),
        .link_voq(link_voq), .link_om(link_om)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Reference: rounds of grant (from link pointer) and accept (from queue pointer).
    task automatic model_match(input logic [NV-1:0] ne);
        bit vm [NV];
        int g [NL];
        for (int v = 0; v < NV; v++) vm[v] = 0;
        for (int r = 0; r < NL; r++) begin mv[r] = -1; fst[r] = 0; end
        for (int it = 0; it < NI; it++) begin
            for (int r = 0; r < NL; r++) begin
                g[r] = -1;
                if (mv[r] < 0)
                    for (int k = 0; k < NV; k++) begin
                        int v = (pl[r] + k) % NV;
                        if (g[r] < 0 && ne[v] && !vm[v]) g[r] = v;
                    end
            end
            for (int v = 0; v < NV; v++) begin
                if (ne[v] && !vm[v])
                    for (int k = 0; k < NL; k++) begin
                        int r = (pv[v] + k) % NL;
                        if (!vm[v] && g[r] == v) begin
                            vm[v] = 1; mv[r] = v; fst[r] = (it == 0);
                        end
                    end
            end
        end
    endtask

    task automatic run_slot(input logic [NV-1:0] ne, input logic [NL-1:0] cg, input bit glitch);
        @(negedge clk);
        slot_start = 1'b1;
        voq_nonempty = ne;
        @(negedge clk);
        slot_start = glitch;       // R8: seen in ST_REQ, must be ignored
        voq_nonempty = ~ne;        // R9: scrambled after capture
        for (int i = 0; i < NI; i++) begin
            @(negedge clk);
            slot_start = 1'b0;
        end
        chk(cand_ready == 1'b0, "R7 early ready", cand_ready, 0);
        @(negedge clk);
        chk(cand_ready == 1'b1, "R7 ready timing", cand_ready, 1);
        model_match(ne);
        for (int r = 0; r < NL; r++) begin
            int ev = (mv[r] >= 0) ? 1 : 0;
            int av = link_valid[r];
            int aq = link_voq[r*VW +: VW];
            int ao = link_om[r*OW +: OW];
            chk(av == ev, "R4/R5 link valid", av, ev);
            if (ev == 1) begin
                chk(aq == mv[r], "R3/R4/R5/R9 link queue", aq, mv[r]);
                chk(ao == mv[r] % NO, "R2 link module", ao, mv[r] % NO);
            end
        end
        cm_reply_valid = 1'b1;
        cm_grant = cg;
        @(negedge clk);
        cm_reply_valid = 1'b0;
        cm_grant = '0;
        @(negedge clk);
        chk(cand_ready == 1'b0 && link_valid == '0, "R8 idle after update",
            int'(link_valid), 0);
        // R6: reference pointer motion
        for (int r = 0; r < NL; r++)
            if (mv[r] >= 0 && fst[r] && cg[r]) begin
                pl[r] = (mv[r] + 1) % NV;
                pv[mv[r]] = (r + 1) % NL;
            end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int r = 0; r < NL; r++) pl[r] = 0;   // R1: pointers start at 0
        for (int v = 0; v < NV; v++) pv[v] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cand_ready == 1'b0, "R1 reset ready", cand_ready, 0);
        chk(link_valid == '0, "R1 reset valid", int'(link_valid), 0);
        // R6 sweep: all nonempty patterns under all central-grant patterns
        for (int s = 0; s < 128; s++)
            run_slot(NV'(s % 16), NL'((s / 16) % 8), s[0]);
        // directed: all queues full, grants withheld then given
        run_slot('1, '0, 1'b0);
        run_slot('1, '1, 1'b0);
        run_slot('1, '1, 1'b1);
        run_slot(4'b1001, 3'b101, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule